// File: doc/BRIEF.md
# Two-Stage Hierarchical Shifting Network

This block holds a 64-bit register image. It presents that image to a downstream codec as an aligned window, and the codec consumes the image a few bits at a time. A single 64-bit barrel shifter could serve any offset. This block instead splits the work into two parts. A coarse stage moves the whole word down by a fixed step of N bits, and it needs no multiplexers because each bit simply takes its neighbour N places above. A small 2N-bit barrel shifter then works only on the lowest 2N bits of the word and supplies the fine alignment.

The codec loads a word and then issues advance requests, each with an amount from 0 to N. The block keeps an offset inside the 2N-bit head. When an advance carries that offset to N or beyond, the coarse stage fires and the offset wraps, both in the same cycle. The codec always sees its next unconsumed bit at bit 0 of the window. A counter reports how many loaded bits are still unconsumed.

Top module: `hier_shift_net`

## Requirements
- R1: During and after reset, with no load yet, the window output reads all zeros and the remaining count reads 0.
- R2: In the cycle after a load, the window equals bits 15:0 of the loaded word and the remaining count equals 64. Bit 0 of the loaded word is the first bit consumed.
- R3: A load takes priority over an advance requested in the same cycle. The advance amount has no effect on the window or the count.
- R4: Let C be the total number of bits advanced since the last load. After each advance, window bit j equals loaded-word bit C+j for every j below 16 − (C mod 8) where C+j < 64.
- R5: An advance of 0 leaves the window and the count unchanged.
- R6: When the in-head offset plus the advance amount reaches 8 or more, the word moves down by exactly 8 bits and the offset wraps by 8 in that same cycle. The data seen in the window stays contiguous across the step.
- R7: Window bits at positions 16 − (C mod 8) and above read zero, and so do bits that lie past the end of the loaded word.
- R8: Each advance lowers the remaining count by its amount, saturating at 0. Once the count is 0 the window reads all zeros.
- R9: An advance amount above 8 on the 4-bit amount input is treated as exactly 8.
- R10: With neither load nor advance asserted, the window and the count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new word this cycle |
| load_data_i | input | 64 | Word to load; bit 0 is consumed first |
| adv_i | input | 1 | Advance request |
| adv_amt_i | input | 4 | Bits to consume, 0 to 8 (larger values clamp to 8) |
| window_o | output | 16 | Aligned window; bit 0 is the next unconsumed bit |
| remain_o | output | 7 | Number of loaded bits not yet consumed |

## Verification
The bound checker watches the remaining count on every cycle. It checks that the count never exceeds 64 and is 64 right after a load. It checks that an in-range advance subtracts exactly its amount, that a count of zero stays at zero, and that idle and zero-amount cycles change neither output. Window contents cannot be checked that way: contiguity across coarse steps, zero fill above the valid head and the clamping of oversized amounts only show up when the bench compares every cycle against a model of the loaded word and the total consumed. The bench drives that comparison through directed boundary crossings and a long random mix of loads and advances.

// File: rtl/hsn_pkg.sv
package hsn_pkg;

    localparam int HSN_WORD_W = 64;
    localparam int HSN_STEP_W = 8;

    // Action chosen for the coming cycle, in priority order.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_FINE   = 2'd1,
        ACT_COARSE = 2'd2,
        ACT_LOAD   = 2'd3
    } hsn_act_e;

endpackage

// File: rtl/hsn_coarse_step.sv
// Fixed right move by STEP_W bits, zero fill at the top; pure wiring.
module hsn_coarse_step #(
    parameter int WORD_W = 64,
    parameter int STEP_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o
);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i < WORD_W - STEP_W) begin : g_move
            assign word_o[i] = word_i[i + STEP_W];
        end else begin : g_fill
            assign word_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/hsn_fine_barrel.sv
// Logarithmic right shifter over the head, zero fill.
module hsn_fine_barrel #(
    parameter int HEAD_W = 16,
    localparam int SH_W  = $clog2(HEAD_W)
) (
    input  logic [HEAD_W-1:0] head_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [HEAD_W-1:0] win_o
);

    logic [HEAD_W-1:0] lvl [SH_W+1];

    assign lvl[0] = head_i;

    for (genvar l = 0; l < SH_W; l++) begin : g_lvl
        localparam int DIST = 1 << l;
        for (genvar i = 0; i < HEAD_W; i++) begin : g_bit
            if (i + DIST < HEAD_W) begin : g_mux
                assign lvl[l+1][i] = shamt_i[l] ? lvl[l][i + DIST] : lvl[l][i];
            end else begin : g_edge
                assign lvl[l+1][i] = shamt_i[l] ? 1'b0 : lvl[l][i];
            end
        end
    end

    assign win_o = lvl[SH_W];

endmodule

// File: rtl/hier_shift_net.sv
module hier_shift_net
    import hsn_pkg::*;
#(
    parameter int WORD_W = HSN_WORD_W,
    parameter int STEP_W = HSN_STEP_W,
    localparam int HEAD_W = 2 * STEP_W,
    localparam int AMT_W  = $clog2(STEP_W + 1),
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_data_i,
    input  logic              adv_i,
    input  logic [AMT_W-1:0]  adv_amt_i,
    output logic [HEAD_W-1:0] window_o,
    output logic [CNT_W-1:0]  remain_o
);

    localparam int OFF_W = $clog2(STEP_W);
    localparam int SH_W  = $clog2(HEAD_W);
    localparam int SUM_W = AMT_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [OFF_W-1:0]  off;
        logic [CNT_W-1:0]  remain;
    } state_t;

    state_t            st_d, st_q;
    hsn_act_e          act;
    logic [AMT_W-1:0]  amt_eff;
    logic [SUM_W-1:0]  sum;
    logic [WORD_W-1:0] stepped;

    hsn_coarse_step #(
        .WORD_W (WORD_W),
        .STEP_W (STEP_W)
    ) u_coarse (
        .word_i (st_q.word),
        .word_o (stepped)
    );

    hsn_fine_barrel #(
        .HEAD_W (HEAD_W)
    ) u_fine (
        .head_i  (st_q.word[HEAD_W-1:0]),
        .shamt_i ({{(SH_W - OFF_W){1'b0}}, st_q.off}),
        .win_o   (window_o)
    );

    assign remain_o = st_q.remain;

    always_comb begin
        amt_eff = (adv_amt_i > AMT_W'(STEP_W)) ? AMT_W'(STEP_W) : adv_amt_i;
        sum     = SUM_W'(st_q.off) + SUM_W'(amt_eff);

        if (load_i) begin
            act = ACT_LOAD;
        end else if (adv_i) begin
            act = (sum >= SUM_W'(STEP_W)) ? ACT_COARSE : ACT_FINE;
        end else begin
            act = ACT_IDLE;
        end

        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.word   = load_data_i;
                st_d.off    = '0;
                st_d.remain = CNT_W'(WORD_W);
            end
            ACT_FINE, ACT_COARSE: begin
                if (act == ACT_COARSE) begin
                    st_d.word = stepped;
                    st_d.off  = OFF_W'(sum - SUM_W'(STEP_W));
                end else begin
                    st_d.off  = OFF_W'(sum);
                end
                st_d.remain = (st_q.remain > CNT_W'(amt_eff))
                            ? st_q.remain - CNT_W'(amt_eff) : '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hier_shift_net_chk.sv
module hier_shift_net_chk #(
    parameter int WORD_W = 64,
    parameter int STEP_W = 8,
    localparam int HEAD_W = 2 * STEP_W,
    localparam int AMT_W  = $clog2(STEP_W + 1),
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_i,
    input logic [AMT_W-1:0]  adv_amt_i,
    input logic [HEAD_W-1:0] window_o,
    input logic [CNT_W-1:0]  remain_o
);

    assert_remain_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        remain_o <= CNT_W'(WORD_W));

    assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> remain_o == CNT_W'(WORD_W));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(window_o) && $stable(remain_o)));

    assert_zero_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && adv_amt_i == '0) |=> ($stable(window_o) && $stable(remain_o)));

    assert_decrement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && adv_amt_i <= AMT_W'(STEP_W) && remain_o >= CNT_W'(adv_amt_i))
        |=> remain_o == $past(remain_o) - CNT_W'($past(adv_amt_i)));

    assert_empty_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && remain_o == '0) |=> remain_o == '0);

endmodule

bind hier_shift_net hier_shift_net_chk #(
    .WORD_W (WORD_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .adv_i     (adv_i),
    .adv_amt_i (adv_amt_i),
    .window_o  (window_o),
    .remain_o  (remain_o)
);

// File: tb/tb_hier_shift_net.sv
module tb_hier_shift_net;

    localparam int WORD_W = 64;
    localparam int STEP_W = 8;
    localparam int HEAD_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [WORD_W-1:0] load_data_i = '0;
    logic              adv_i = 1'b0;
    logic [3:0]        adv_amt_i = '0;
    logic [HEAD_W-1:0] window_o;
    logic [6:0]        remain_o;

    int checks = 0;
    int errors = 0;

    logic [WORD_W-1:0] m_word = '0;
    int                m_used = WORD_W;

    always #10 clk = ~clk;

    hier_shift_net dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_data_i (load_data_i),
        .adv_i       (adv_i),
        .adv_amt_i   (adv_amt_i),
        .window_o    (window_o),
        .remain_o    (remain_o)
    );

    function automatic logic [HEAD_W-1:0] exp_window(logic [WORD_W-1:0] w, int used);
        int off  = used % STEP_W;
        int base = used - off;
        logic [HEAD_W-1:0] head;
        if (base >= WORD_W) return '0;
        head = HEAD_W'(w >> base);
        return head >> off;
    endfunction

    function automatic logic [6:0] exp_remain(int used);
        return (used >= WORD_W) ? 7'd0 : 7'(WORD_W - used);
    endfunction

    task automatic check(string req, logic [HEAD_W-1:0] exp_w, logic [6:0] exp_r);
        checks++;
        if (window_o !== exp_w || remain_o !== exp_r) begin
            errors++;
            $display("FAIL %s window=%h exp=%h remain=%0d exp=%0d",
                     req, window_o, exp_w, remain_o, exp_r);
        end
    endtask

    task automatic check_model(string req);
        check(req, exp_window(m_word, m_used), exp_remain(m_used));
    endtask

    task automatic do_load(logic [WORD_W-1:0] d, logic with_adv, logic [3:0] amt);
        load_i = 1'b1; load_data_i = d; adv_i = with_adv; adv_amt_i = amt;
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0;
        m_word = d; m_used = 0;
    endtask

    task automatic do_adv(logic [3:0] amt);
        adv_i = 1'b1; adv_amt_i = amt;
        @(negedge clk);
        adv_i = 1'b0;
        m_used += (amt > 4'd8) ? 8 : int'(amt);
    endtask

    task automatic do_idle();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] pat;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        check("R1", 16'h0000, 7'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000, 7'd0);

        pat = 64'hFEDC_BA98_7654_3210;
        do_load(pat, 1'b0, 4'd0);
        check("R2", 16'h3210, 7'd64);

        do_adv(4'd0);
        check("R5", 16'h3210, 7'd64);

        do_adv(4'd4);
        check_model("R4");
        check("R7", 16'h0321, 7'd60);

        do_adv(4'd7);
        check_model("R6");

        do_idle();
        check_model("R10");

        do_adv(4'd15);
        check_model("R9");

        do_load(64'h0123_4567_89AB_CDEF, 1'b1, 4'd5);
        check("R3", 16'hCDEF, 7'd64);

        for (int k = 0; k < 7; k++) begin
            do_adv(4'd8);
            check_model("R6");
        end
        do_adv(4'd3);
        check_model("R4");
        do_adv(4'd8);
        check("R8", 16'h0000, 7'd0);
        do_adv(4'd2);
        check("R8", 16'h0000, 7'd0);

        for (int it = 0; it < 600; it++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 6) begin
                pat = {$urandom(), $urandom()};
                do_load(pat, r[0], 4'($urandom_range(0, 15)));
                check_model("R2");
            end else if (r < 80) begin
                do_adv(4'($urandom_range(0, 15)));
                check_model("R4");
            end else begin
                do_idle();
                check_model("R10");
            end
        end

        summary();
        $finish;
    end

endmodule